// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency Complex Butterfly

This block is the arithmetic core of a radix-2 decimation-in-frequency FFT engine. In every clock cycle it can take two complex samples `a` and `b` and one complex twiddle factor `W`. It returns the sum `a+b` as the even result and the twiddled difference `(a-b)*W` as the odd result. The surrounding engine supplies the operands and the twiddle from its own memories and writes both results back. Address generation and storage stay outside this block.

Sample parts are signed fixed-point integers. The twiddle parts are signed fixed-point numbers with two integer bits, so the value 1.0 is the integer 2^(TW_W-2). The difference is multiplied by four real multipliers. Two real adders combine the partial products, and the complex sum then goes through a truncating arithmetic right shift. That multiplier is pipelined over five register levels. The sum travels through a delay line of the same depth, so both results leave together under one valid flag.

Top module: `radix2_dif_bfly`

## Requirements
- R1: The even output is the full-precision sum. `even_re = a_re + b_re` and `even_im = a_im + b_im`, each written as a signed DATA_W+1 bit value.
- R2: The difference is `dr = a_re-b_re`, `di = a_im-b_im`, each a DATA_W+1 bit value. The twiddle is two's complement with 1.0 = 2^(TW_W-2). The odd output is `odd_re = (dr*w_re - di*w_im) >>> (TW_W-2)` and `odd_im = (dr*w_im + di*w_re) >>> (TW_W-2)`, keeping the low DATA_W+1 bits.
- R3: The rescaling truncates toward minus infinity. With dr=3 and w_re=0.5, odd_re is 1. With dr=-3 and w_re=0.5, odd_re is -2.
- R4: A butterfly presented with `in_valid` high in one cycle shows `out_valid` high exactly 5 cycles later. Both its results appear in that same cycle.
- R5: A new butterfly is accepted every cycle. A back-to-back stream yields one result per cycle, in input order, with none lost.
- R6: While `in_valid` is low, the input values have no effect. When `out_valid` is low, all four data outputs hold their previous values.
- R7: A synchronous active-high `rst` clears `out_valid` and all data outputs to zero. Butterflies in flight when reset is applied never produce a result.
- R8: W = 1 (w_re = 2^(TW_W-2), w_im = 0) gives odd = a-b. W = -j (w_re = 0, w_im = -2^(TW_W-2)) gives odd_re = di and odd_im = -dr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and twiddle valid this cycle |
| a_re | input | DATA_W | Operand a, real part |
| a_im | input | DATA_W | Operand a, imaginary part |
| b_re | input | DATA_W | Operand b, real part |
| b_im | input | DATA_W | Operand b, imaginary part |
| w_re | input | TW_W | Twiddle real part, 1.0 = 2^(TW_W-2) |
| w_im | input | TW_W | Twiddle imaginary part |
| out_valid | output | 1 | Results valid this cycle |
| even_re | output | DATA_W+1 | Real part of a+b |
| even_im | output | DATA_W+1 | Imaginary part of a+b |
| odd_re | output | DATA_W+1 | Real part of (a-b)*W |
| odd_im | output | DATA_W+1 | Imaginary part of (a-b)*W |

## Verification
The butterfly is driven with twiddles of 1 and -j. These isolate the subtract path and the real/imaginary swap with sign flip, and they rule out any mixing of the multiplier cross terms. Full-scale operands of opposite sign, paired with W = 1 and W = -1, exercise the widest difference. A unit-magnitude diagonal twiddle stresses all four products at once. Half-scale twiddles on odd differences of either sign show floor truncation rather than rounding. Equal operands give a zero difference with a nonzero twiddle, and idle gaps carrying garbage data, together with a reset while butterflies are in flight, show that only valid work reaches the outputs.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    // default sample and twiddle widths
    localparam int DATA_W_DEF = 24;
    localparam int TW_W_DEF   = 32;
    // register levels in the twiddle multiplier; sum path matches it
    localparam int PIPE_LAT   = 5;
endpackage

// File: rtl/bfly_presum.sv
module bfly_presum #(
    parameter int DW = bfly_pkg::DATA_W_DEF,
    localparam int OW = DW + 1
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic signed [OW-1:0] sum_re,
    output logic signed [OW-1:0] sum_im,
    output logic signed [OW-1:0] dif_re,
    output logic signed [OW-1:0] dif_im
);
    always_comb begin
        sum_re = OW'(a_re) + OW'(b_re);
        sum_im = OW'(a_im) + OW'(b_im);
        dif_re = OW'(a_re) - OW'(b_re);
        dif_im = OW'(a_im) - OW'(b_im);
    end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
    parameter int DW = bfly_pkg::DATA_W_DEF + 1,
    parameter int TW = bfly_pkg::TW_W_DEF,
    localparam int PW   = DW + TW,
    localparam int SW   = PW + 1,
    localparam int FRAC = TW - 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    typedef struct packed {
        // level 1: operand capture
        logic                 v1;
        logic signed [DW-1:0] xr;
        logic signed [DW-1:0] xi;
        logic signed [TW-1:0] wr;
        logic signed [TW-1:0] wi;
        // level 2: raw products
        logic                 v2;
        logic signed [PW-1:0] p_rr;
        logic signed [PW-1:0] p_ii;
        logic signed [PW-1:0] p_ri;
        logic signed [PW-1:0] p_ir;
        // level 3: product retiming
        logic                 v3;
        logic signed [PW-1:0] q_rr;
        logic signed [PW-1:0] q_ii;
        logic signed [PW-1:0] q_ri;
        logic signed [PW-1:0] q_ir;
        // level 4: cross-term sums
        logic                 v4;
        logic signed [SW-1:0] s_re;
        logic signed [SW-1:0] s_im;
        // level 5: rescaled output
        logic                 v5;
        logic signed [DW-1:0] o_re;
        logic signed [DW-1:0] o_im;
    } mul_st_t;

    mul_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.xr = x_re;
            st_d.xi = x_im;
            st_d.wr = w_re;
            st_d.wi = w_im;
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.p_rr = PW'(st_q.xr) * PW'(st_q.wr);
            st_d.p_ii = PW'(st_q.xi) * PW'(st_q.wi);
            st_d.p_ri = PW'(st_q.xr) * PW'(st_q.wi);
            st_d.p_ir = PW'(st_q.xi) * PW'(st_q.wr);
        end
        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.q_rr = st_q.p_rr;
            st_d.q_ii = st_q.p_ii;
            st_d.q_ri = st_q.p_ri;
            st_d.q_ir = st_q.p_ir;
        end
        st_d.v4 = st_q.v3;
        if (st_q.v3) begin
            st_d.s_re = SW'(st_q.q_rr) - SW'(st_q.q_ii);
            st_d.s_im = SW'(st_q.q_ri) + SW'(st_q.q_ir);
        end
        st_d.v5 = st_q.v4;
        if (st_q.v4) begin
            st_d.o_re = DW'(st_q.s_re >>> FRAC);
            st_d.o_im = DW'(st_q.s_im >>> FRAC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.v5;
    assign y_re      = st_q.o_re;
    assign y_im      = st_q.o_im;
endmodule

// File: rtl/bfly_delay.sv
module bfly_delay #(
    parameter int W     = 2 * (bfly_pkg::DATA_W_DEF + 1),
    parameter int DEPTH = bfly_pkg::PIPE_LAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] dat_d [DEPTH];
    logic [W-1:0] dat_q [DEPTH];
    logic         vld_d [DEPTH];
    logic         vld_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        if (g == 0) begin : g_head
            always_comb begin
                vld_d[g] = in_valid;
                dat_d[g] = in_valid ? din : dat_q[g];
            end
        end else begin : g_body
            always_comb begin
                vld_d[g] = vld_q[g-1];
                dat_d[g] = vld_q[g-1] ? dat_q[g-1] : dat_q[g];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
                dat_q[g] <= '0;
            end else begin
                vld_q[g] <= vld_d[g];
                dat_q[g] <= dat_d[g];
            end
        end
    end

    assign dout = dat_q[DEPTH-1];
endmodule

// File: rtl/radix2_dif_bfly.sv
module radix2_dif_bfly #(
    parameter int DATA_W = bfly_pkg::DATA_W_DEF,
    parameter int TW_W   = bfly_pkg::TW_W_DEF,
    localparam int OW    = DATA_W + 1,
    localparam int LAT   = bfly_pkg::PIPE_LAT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [DATA_W-1:0] b_re,
    input  logic signed [DATA_W-1:0] b_im,
    input  logic signed [TW_W-1:0]   w_re,
    input  logic signed [TW_W-1:0]   w_im,
    output logic                     out_valid,
    output logic signed [OW-1:0]     even_re,
    output logic signed [OW-1:0]     even_im,
    output logic signed [OW-1:0]     odd_re,
    output logic signed [OW-1:0]     odd_im
);
    logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic [2*OW-1:0]      sum_late;

    bfly_presum #(.DW(DATA_W)) u_pre (
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .sum_re(sum_re), .sum_im(sum_im),
        .dif_re(dif_re), .dif_im(dif_im)
    );

    bfly_cmul #(.DW(OW), .TW(TW_W)) u_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .x_re(dif_re), .x_im(dif_im), .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid), .y_re(odd_re), .y_im(odd_im)
    );

    bfly_delay #(.W(2*OW), .DEPTH(LAT)) u_dly (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .din({sum_re, sum_im}), .dout(sum_late)
    );

    assign even_re = sum_late[2*OW-1:OW];
    assign even_im = sum_late[OW-1:0];
endmodule

// File: rtl/bfly_chk.sv
module bfly_chk #(
    parameter int DW = bfly_pkg::DATA_W_DEF,
    localparam int OW  = DW + 1,
    localparam int LAT = bfly_pkg::PIPE_LAT
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [DW-1:0] a_re,
    input logic signed [DW-1:0] a_im,
    input logic signed [DW-1:0] b_re,
    input logic signed [DW-1:0] b_im,
    input logic                 out_valid,
    input logic signed [OW-1:0] even_re,
    input logic signed [OW-1:0] even_im,
    input logic signed [OW-1:0] odd_re,
    input logic signed [OW-1:0] odd_im
);
    logic                 vsh  [LAT];
    logic signed [OW-1:0] e_re [LAT];
    logic signed [OW-1:0] e_im [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                vsh[i]  <= 1'b0;
                e_re[i] <= '0;
                e_im[i] <= '0;
            end
        end else begin
            vsh[0]  <= in_valid;
            e_re[0] <= OW'(a_re) + OW'(b_re);
            e_im[0] <= OW'(a_im) + OW'(b_im);
            for (int i = 1; i < LAT; i++) begin
                vsh[i]  <= vsh[i-1];
                e_re[i] <= e_re[i-1];
                e_im[i] <= e_im[i-1];
            end
        end
    end

    assert_valid_latency_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsh[LAT-1]);

    assert_even_sum_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (even_re == e_re[LAT-1] && even_im == e_im[LAT-1]));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(even_re) && $stable(even_im) &&
                        $stable(odd_re) && $stable(odd_im)));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && even_re == '0 && odd_re == '0 &&
                        even_im == '0 && odd_im == '0));
endmodule

bind radix2_dif_bfly bfly_chk #(.DW(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid),
    .even_re(even_re), .even_im(even_im),
    .odd_re(odd_re), .odd_im(odd_im)
);

// File: tb/sim_radix2_dif_bfly.sv
module sim_radix2_dif_bfly;
    localparam int DW  = 24;
    localparam int TW  = 32;
    localparam int OW  = DW + 1;
    localparam int ONE = 1 << (TW - 2);
    localparam int NV  = 8;
    localparam int MAXQ = 64;

    // stimulus table: a_re, a_im, b_re, b_im, w_re, w_im
    localparam int T_AR[NV] = '{1000, -5000, 8388607, -8388608, 123456, 3, -3, -77};
    localparam int T_AI[NV] = '{-2000, 7000, 8388607, 0, -654321, 0, 0, 55};
    localparam int T_BR[NV] = '{300, 1234, -8388608, 8388607, -111111, 0, 0, -77};
    localparam int T_BI[NV] = '{500, -4321, -8388608, 0, 222222, 0, 0, 55};
    localparam int T_WR[NV] = '{ONE, 0, ONE, -ONE, 759250125, ONE/2, ONE/2, 12345678};
    localparam int T_WI[NV] = '{0, -ONE, 0, 0, -759250125, 0, 0, -87654321};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic signed [TW-1:0] w_re = '0, w_im = '0;
    logic                 out_valid;
    logic signed [OW-1:0] even_re, even_im, odd_re, odd_im;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nin = 0;
    int nout = 0;
    bit done = 1'b0;

    longint x_er[MAXQ], x_ei[MAXQ], x_or[MAXQ], x_oi[MAXQ];
    int     x_cyc[MAXQ];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    radix2_dif_bfly #(.DATA_W(DW), .TW_W(TW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im),
        .out_valid(out_valid),
        .even_re(even_re), .even_im(even_im),
        .odd_re(odd_re), .odd_im(odd_im)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint wrap25(input longint v);
        logic signed [OW-1:0] t;
        t = v[OW-1:0];
        return longint'(t);
    endfunction

    task automatic push(input int ar, input int ai, input int br, input int bi,
                        input int wr, input int wi);
        longint dr, di;
        @(negedge clk);
        a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
        w_re = wr; w_im = wi;
        in_valid = 1'b1;
        dr = longint'(ar) - longint'(br);
        di = longint'(ai) - longint'(bi);
        x_er[nin]  = longint'(ar) + longint'(br);
        x_ei[nin]  = longint'(ai) + longint'(bi);
        x_or[nin]  = wrap25((dr * wr - di * wi) >>> (TW - 2));
        x_oi[nin]  = wrap25((dr * wi + di * wr) >>> (TW - 2));
        x_cyc[nin] = cyc;
        nin++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_re = DW'(32'h5A5A5A + i * 77); b_re = DW'(-i * 991);
            a_im = DW'(i * 12345); b_im = DW'(32'h123456);
            w_re = 32'h3000_0000 - i; w_im = i * 1000;
        end
    endtask

    // result monitor: R1, R2, R4, R5, R6
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (nout >= nin) begin
                chk(1'b0, "R6 spurious out_valid", 1, 0);
            end else begin
                chk(longint'(even_re) == x_er[nout], "R1 even_re", longint'(even_re), x_er[nout]);
                chk(longint'(even_im) == x_ei[nout], "R1 even_im", longint'(even_im), x_ei[nout]);
                chk(longint'(odd_re) == x_or[nout], "R2 odd_re", longint'(odd_re), x_or[nout]);
                chk(longint'(odd_im) == x_oi[nout], "R2 odd_im", longint'(odd_im), x_oi[nout]);
                chk(cyc - x_cyc[nout] == 5, "R4 latency", cyc - x_cyc[nout], 5);
                nout++;
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk(out_valid == 1'b0, "R7 out_valid after reset", out_valid, 0);
        chk(even_re == '0 && even_im == '0 && odd_re == '0 && odd_im == '0,
            "R7 outputs zero after reset", longint'(even_re), 0);

        // R5 back-to-back stream through the table
        for (int k = 0; k < NV; k++) push(T_AR[k], T_AI[k], T_BR[k], T_BI[k], T_WR[k], T_WI[k]);
        idle(8);
        chk(nout == nin, "R5 all results delivered", nout, nin);

        // R8 W = 1
        push(4000, -1500, 1000, 2500, ONE, 0);
        idle(6);
        chk(longint'(odd_re) == 3000, "R8 W=1 odd_re", longint'(odd_re), 3000);
        chk(longint'(odd_im) == -4000, "R8 W=1 odd_im", longint'(odd_im), -4000);

        // R8 W = -j
        push(4000, -1500, 1000, 2500, 0, -ONE);
        idle(6);
        chk(longint'(odd_re) == -4000, "R8 W=-j odd_re", longint'(odd_re), -4000);
        chk(longint'(odd_im) == -3000, "R8 W=-j odd_im", longint'(odd_im), -3000);

        // R3 floor truncation on a negative half
        push(-3, 0, 0, 0, ONE / 2, 0);
        idle(6);
        chk(longint'(odd_re) == -2, "R3 floor of -1.5", longint'(odd_re), -2);
        push(3, 0, 0, 0, ONE / 2, 0);
        idle(6);
        chk(longint'(odd_re) == 1, "R3 floor of 1.5", longint'(odd_re), 1);

        // R6 hold during long idle with garbage inputs
        push(-9999, 8888, 7777, -6666, ONE / 4, ONE / 4);
        idle(12);
        chk(longint'(even_re) == x_er[nin-1], "R6 even_re held", longint'(even_re), x_er[nin-1]);
        chk(longint'(odd_im) == x_oi[nin-1], "R6 odd_im held", longint'(odd_im), x_oi[nin-1]);
        chk(out_valid == 1'b0, "R6 out_valid low in idle", out_valid, 0);

        // R7 reset with butterflies in flight
        push(11, 22, 33, 44, ONE, 0);
        push(55, 66, 77, 88, ONE, 0);
        push(99, 11, 22, 33, ONE, 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        nout = nin;
        chk(out_valid == 1'b0, "R7 out_valid cleared", out_valid, 0);
        chk(even_re == '0 && odd_im == '0, "R7 data cleared", longint'(even_re), 0);
        idle(8);
        chk(nout == nin, "R7 in-flight work dropped", nout, nin);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule